// File: doc/BRIEF.md
# Two-Level Page Walker with Access Protection

This block turns a 32-bit linear address into a physical address by walking a two-level translation structure held in memory. For each request it fetches one directory entry and then one table entry over a simple read port. It then applies the page-level permission rules for the requesting privilege level and returns either the translated address or a page fault together with a three-bit reason code. The directory's location comes from a base register that is written through a configuration strobe.

The directory is indexed by the top ten address bits and each table by the next ten bits. The low twelve bits pass straight through as the page offset. Both levels use one entry format: bits 31:12 give the next frame, bit 0 marks the entry present, bit 1 allows writes and bit 2 allows the least-privileged level. The effective permission is the tighter of the two entries. The writable bit and the user bit only restrict privilege level 3. A memory read may take any number of cycles. The block takes one request at a time.

Top module: `pw_top`

## Requirements
- R1: After synchronous reset the walker is idle: `req_ready` is 1, and `rsp_done` and `mem_rd_req` are 0.
- R2: The first read goes to `base + vaddr[31:22]*4`, where `base` is the configured directory base with its low 12 bits taken as zero. The second read goes to `{dir_entry[31:12], 12'h000} + vaddr[21:12]*4`.
- R3: A permitted access completes with `rsp_fault`=0, `rsp_code`=3'b000 and `rsp_paddr` = `{tbl_entry[31:12], vaddr[11:0]}`.
- R4: When directory entry bit 0 (present) is 0, the walk faults with `rsp_code[0]`=0 at every privilege level, and no table entry is read.
- R5: When table entry bit 0 is 0 and the directory entry is present, the walk faults with `rsp_code[0]`=0 at every privilege level, after exactly two reads.
- R6: When bit 2 (user) is 0 in either entry, any level-3 access faults with `rsp_code[0]`=1. The same access at levels 0, 1 and 2 succeeds.
- R7: When the user bit is 1 in both entries and bit 1 (writable) is 0 in either entry, a level-3 write faults with `rsp_code[0]`=1. A level-3 read succeeds, and a write at levels 0 to 2 succeeds.
- R8: When the user bit denies level 3, the writable bit is not consulted, so a level-3 read faults whatever the writable bits hold. A table entry cannot loosen a denial made by its directory entry.
- R9: On a fault, `rsp_code[1]` equals the request's write flag and `rsp_code[2]` is 1 exactly when the request came from privilege level 3.
- R10: `rsp_done` is high for exactly one cycle per walk. `rsp_fault`, `rsp_code` and `rsp_paddr` hold their values until the next completion.
- R11: A request is taken only while `req_ready` is 1. `req_valid` during a walk is ignored: the walk in flight issues its own two reads and returns its own result.
- R12: `mem_rd_req` stays high with a stable `mem_rd_addr` until `mem_rd_valid` is seen, so any read latency gives the same result.
- R13: A write with `cfg_base_we` loads the directory base from `cfg_base_wdata[31:12]`. Walks that begin afterwards use the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_base_we | input | 1 | Directory base load strobe |
| cfg_base_wdata | input | 32 | New directory base; bits 31:12 are used |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 for a write access |
| req_cpl | input | 2 | Privilege level of the access, 0 to 3 |
| mem_rd_req | output | 1 | Entry read request, held until answered |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Entry read from memory |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Walk ended in a page fault |
| rsp_paddr | output | 32 | Translated physical address, zero on a fault |
| rsp_code | output | 3 | Fault reason: bit0 protection, bit1 write, bit2 level 3 |

## Verification
Internal state is visible at the ports quickly. A wrong latched access attribute shows in `rsp_code` on the completion of the same walk. A wrong stored frame shows in the second read address, one cycle after the first read returns, or else in `rsp_paddr`. If the FSM skips or repeats a state, the number of reads changes, `rsp_done` pulses more or fewer times than once, or `req_ready` rises while a read is still outstanding. Each of these appears within the walk in which the error happens.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_DIR,
        ST_CHECK_DIR,
        ST_READ_TBL,
        ST_CHECK_TBL,
        ST_DONE
    } pw_state_e;

    // control field shared by directory and table entries
    localparam int CTL_W        = 3;
    localparam int BIT_PRESENT  = 0;
    localparam int BIT_WRITABLE = 1;
    localparam int BIT_USER     = 2;

    // fault reason code layout
    localparam int CODE_W       = 3;
    localparam int FC_PROT      = 0;
    localparam int FC_WRITE     = 1;
    localparam int FC_USER      = 2;

    // privilege level that the page bits restrict
    localparam logic [1:0] LEAST_PRIV = 2'd3;

endpackage

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
    parameter int ADDR_W      = 32,
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 10,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [ADDR_W-OFF_W-1:0] frame,
    input  logic [IDX_W-1:0]        index,
    output logic [ADDR_W-1:0]       addr
);
    localparam int SHIFT = $clog2(ENTRY_BYTES);

    logic [ADDR_W-1:0] base_bytes;
    logic [ADDR_W-1:0] offset_bytes;

    assign base_bytes   = {frame, {OFF_W{1'b0}}};
    assign offset_bytes = ADDR_W'({index, {SHIFT{1'b0}}});
    assign addr         = base_bytes + offset_bytes;
endmodule

// File: rtl/pw_perm_check.sv
module pw_perm_check
    import pw_pkg::*;
(
    input  logic [CTL_W-1:0] dir_ctl,
    input  logic [CTL_W-1:0] tbl_ctl,
    input  logic             is_user,
    input  logic             is_write,
    output logic             dir_missing,
    output logic             tbl_missing,
    output logic             prot_deny
);
    logic user_ok;
    logic write_ok;

    assign dir_missing = ~dir_ctl[BIT_PRESENT];
    assign tbl_missing = ~tbl_ctl[BIT_PRESENT];

    // the tighter of the two levels wins
    assign user_ok  = dir_ctl[BIT_USER] & tbl_ctl[BIT_USER];
    assign write_ok = dir_ctl[BIT_WRITABLE] & tbl_ctl[BIT_WRITABLE];

    // writable bit only matters once user access is granted
    assign prot_deny = is_user & (~user_ok | (is_write & ~write_ok));
endmodule

// File: rtl/pw_fault_code.sv
module pw_fault_code
    import pw_pkg::*;
(
    input  logic              is_prot,
    input  logic              is_write,
    input  logic              is_user,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        code           = '0;
        code[FC_PROT]  = is_prot;
        code[FC_WRITE] = is_write;
        code[FC_USER]  = is_user;
    end
endmodule

// File: rtl/pw_top.sv
module pw_top
    import pw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 10,
    parameter int OFF_W       = 12,
    parameter int ENTRY_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_base_we,
    input  logic [ADDR_W-1:0] cfg_base_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic [1:0]        req_cpl,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              rsp_done,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [2:0]        rsp_code
);
    localparam int FRAME_W  = ADDR_W - OFF_W;
    localparam int DIR_LO   = OFF_W + IDX_W;
    localparam int TBL_LO   = OFF_W;

    typedef struct packed {
        pw_state_e          st;
        logic [FRAME_W-1:0] base_frame;
        logic [ADDR_W-1:0]  va;
        logic               wr;
        logic               usr;
        logic [FRAME_W-1:0] tbl_frame;
        logic [CTL_W-1:0]   dir_ctl;
        logic [FRAME_W-1:0] pg_frame;
        logic [CTL_W-1:0]   pg_ctl;
        logic               done;
        logic               fault;
        logic [ADDR_W-1:0]  pa;
        logic [CODE_W-1:0]  code;
    } walk_s;

    walk_s q, d;

    logic [ADDR_W-1:0] dir_entry_addr;
    logic [ADDR_W-1:0] tbl_entry_addr;
    logic              dir_missing;
    logic              tbl_missing;
    logic              prot_deny;
    logic [CODE_W-1:0] np_code;
    logic [CODE_W-1:0] prot_code;
    logic              unused_bits;

    assign unused_bits = ^{cfg_base_wdata[OFF_W-1:0], mem_rd_data[OFF_W-1:CTL_W]};

    pw_entry_addr #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENTRY_BYTES(ENTRY_BYTES)
    ) u_dir_addr (
        .frame(q.base_frame),
        .index(q.va[DIR_LO +: IDX_W]),
        .addr (dir_entry_addr)
    );

    pw_entry_addr #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENTRY_BYTES(ENTRY_BYTES)
    ) u_tbl_addr (
        .frame(q.tbl_frame),
        .index(q.va[TBL_LO +: IDX_W]),
        .addr (tbl_entry_addr)
    );

    pw_perm_check u_perm (
        .dir_ctl    (q.dir_ctl),
        .tbl_ctl    (q.pg_ctl),
        .is_user    (q.usr),
        .is_write   (q.wr),
        .dir_missing(dir_missing),
        .tbl_missing(tbl_missing),
        .prot_deny  (prot_deny)
    );

    pw_fault_code u_np_code (
        .is_prot (1'b0),
        .is_write(q.wr),
        .is_user (q.usr),
        .code    (np_code)
    );

    pw_fault_code u_prot_code (
        .is_prot (1'b1),
        .is_write(q.wr),
        .is_user (q.usr),
        .code    (prot_code)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (cfg_base_we) begin
            d.base_frame = cfg_base_wdata[ADDR_W-1:OFF_W];
        end
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va  = req_vaddr;
                    d.wr  = req_write;
                    d.usr = (req_cpl == LEAST_PRIV);
                    d.st  = ST_READ_DIR;
                end
            end
            ST_READ_DIR: begin
                if (mem_rd_valid) begin
                    d.tbl_frame = mem_rd_data[ADDR_W-1:OFF_W];
                    d.dir_ctl   = mem_rd_data[CTL_W-1:0];
                    d.st        = ST_CHECK_DIR;
                end
            end
            ST_CHECK_DIR: begin
                if (dir_missing) begin
                    d.st    = ST_DONE;
                    d.done  = 1'b1;
                    d.fault = 1'b1;
                    d.code  = np_code;
                    d.pa    = '0;
                end else begin
                    d.st = ST_READ_TBL;
                end
            end
            ST_READ_TBL: begin
                if (mem_rd_valid) begin
                    d.pg_frame = mem_rd_data[ADDR_W-1:OFF_W];
                    d.pg_ctl   = mem_rd_data[CTL_W-1:0];
                    d.st       = ST_CHECK_TBL;
                end
            end
            ST_CHECK_TBL: begin
                d.st   = ST_DONE;
                d.done = 1'b1;
                if (tbl_missing) begin
                    d.fault = 1'b1;
                    d.code  = np_code;
                    d.pa    = '0;
                end else if (prot_deny) begin
                    d.fault = 1'b1;
                    d.code  = prot_code;
                    d.pa    = '0;
                end else begin
                    d.fault = 1'b0;
                    d.code  = '0;
                    d.pa    = {q.pg_frame, q.va[OFF_W-1:0]};
                end
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.st == ST_IDLE);
    assign mem_rd_req  = (q.st == ST_READ_DIR) || (q.st == ST_READ_TBL);
    assign mem_rd_addr = (q.st == ST_READ_TBL) ? tbl_entry_addr : dir_entry_addr;
    assign rsp_done    = q.done;
    assign rsp_fault   = q.fault;
    assign rsp_paddr   = q.pa;
    assign rsp_code    = q.code;
endmodule

// File: rtl/pw_top_chk.sv
module pw_top_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_rd_req,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rd_valid,
    input logic        rsp_done,
    input logic        rsp_fault,
    input logic [2:0]  rsp_code
);
    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R12: an unanswered read keeps its request and address
    a_r12_read_held: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R11: no read is outstanding while new requests are taken
    a_r11_ready_idle: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_rd_req);

    // R11: an accepted request starts a directory read
    a_r11_accept_reads: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (mem_rd_req && !req_ready));

    // R3: success carries a clear reason code
    a_r3_ok_code: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && !rsp_fault) |-> (rsp_code == 3'b000));

    // R6: protection faults only come from level 3
    a_r6_prot_user_only: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_fault && rsp_code[0]) |-> rsp_code[2]);
endmodule

bind pw_top pw_top_chk u_pw_top_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_valid(mem_rd_valid),
    .rsp_done    (rsp_done),
    .rsp_fault   (rsp_fault),
    .rsp_code    (rsp_code)
);

// File: tb/pw_top_test.sv
module pw_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_base_we;
    logic [31:0] cfg_base_wdata;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic        req_write;
    logic [1:0]  req_cpl;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;
    logic        rsp_done;
    logic        rsp_fault;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_code;

    always #10 clk = ~clk;   // 50 MHz

    pw_top uut (
        .clk(clk), .rst(rst),
        .cfg_base_we(cfg_base_we), .cfg_base_wdata(cfg_base_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_cpl(req_cpl),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .rsp_done(rsp_done), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rsp_code(rsp_code)
    );

    int          vectors = 0;
    int          miscompares = 0;
    int          cycles = 0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] dir_base = 32'h0001_0000;
    int          lat = 0;
    int          wait_cnt = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_addr [2];
    bit          intrude = 0;
    bit          saw_ready_busy;

    logic        g_done, g_fault, g_after;
    logic [2:0]  g_code;
    logic [31:0] g_pa;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            summary();
            $finish;
        end
    end

    // memory responder with programmable latency, driven away from the edge
    always @(negedge clk) begin
        mem_rd_valid <= 1'b0;
        if (mem_rd_req && !mem_rd_valid) begin
            if (wait_cnt >= lat) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 32'h0;
                if (rd_cnt < 2) rd_addr[rd_cnt] = mem_rd_addr;
                rd_cnt++;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    function automatic logic [19:0] tbl_frame_of(input logic [31:0] va);
        return 20'h00200 + {10'd0, va[31:22]};
    endfunction

    function automatic logic [19:0] page_frame_of(input logic [31:0] va);
        return va[31:12] ^ 20'h5A5A5;
    endfunction

    task automatic map(input logic [31:0] va, input logic [2:0] pdc, input logic [2:0] ptc);
        logic [31:0] da, ta;
        da = dir_base + {20'd0, va[31:22], 2'b00};
        ta = {tbl_frame_of(va), 12'h000} + {20'd0, va[21:12], 2'b00};
        mem[da] = {tbl_frame_of(va), 9'd0, pdc};
        mem[ta] = {page_frame_of(va), 9'd0, ptc};
    endtask

    task automatic walk(input logic [31:0] va, input logic wr, input logic [1:0] cpl,
                        input int latency);
        int n;
        lat = latency;
        rd_cnt = 0;
        wait_cnt = 0;
        rd_addr[0] = 32'hx;
        rd_addr[1] = 32'hx;
        saw_ready_busy = 0;
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_cpl = cpl; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_done && n < 500) begin
            if (intrude && n < 3) begin
                req_vaddr = va ^ 32'h00C0_1000;
                req_write = ~wr;
                req_cpl   = ~cpl;
                req_valid = 1'b1;
                if (req_ready) saw_ready_busy = 1;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        g_done = rsp_done; g_fault = rsp_fault; g_code = rsp_code; g_pa = rsp_paddr;
        @(negedge clk);
        g_after = rsp_done;
        chk("R10 done seen", {31'd0, g_done}, 32'd1);
        chk("R10 done one cycle", {31'd0, g_after}, 32'd0);
        chk("R10 result held", rsp_paddr, g_pa);
    endtask

    // expected outcome computed from the permission rules
    task automatic run_case(input string tag, input logic [31:0] va, input logic wr,
                            input logic [1:0] cpl, input logic [2:0] pdc,
                            input logic [2:0] ptc, input int latency);
        bit usr, np, prot;
        logic [2:0] ecode;
        logic [31:0] epa;
        int ereads;
        map(va, pdc, ptc);
        walk(va, wr, cpl, latency);
        usr    = (cpl == 2'd3);
        np     = !pdc[0] || !ptc[0];
        prot   = !np && usr && (!(pdc[2] && ptc[2]) || (wr && !(pdc[1] && ptc[1])));
        ereads = pdc[0] ? 2 : 1;
        if (np || prot) begin
            ecode = {usr, wr, prot};
            epa   = 32'h0;
        end else begin
            ecode = 3'b000;
            epa   = {page_frame_of(va), va[11:0]};
        end
        chk({tag, " fault"}, {31'd0, g_fault}, {31'd0, np || prot});
        chk({tag, " code"},  {29'd0, g_code},  {29'd0, ecode});
        chk({tag, " paddr"}, g_pa, epa);
        chk({tag, " reads"}, rd_cnt, ereads);
        chk({tag, " R2 dir addr"}, rd_addr[0], dir_base + {20'd0, va[31:22], 2'b00});
        if (ereads == 2)
            chk({tag, " R2 tbl addr"}, rd_addr[1],
                {tbl_frame_of(va), 12'h000} + {20'd0, va[21:12], 2'b00});
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 ready", {31'd0, req_ready}, 32'd1);
        chk("R1 done", {31'd0, rsp_done}, 32'd0);
        chk("R1 mem req", {31'd0, mem_rd_req}, 32'd0);
    endtask

    task automatic load_base(input logic [31:0] b);
        @(negedge clk);
        cfg_base_we = 1'b1; cfg_base_wdata = b;
        @(negedge clk);
        cfg_base_we = 1'b0;
        dir_base = {b[31:12], 12'h000};
    endtask

    task automatic t_translate();
        run_case("R3 user read",        32'h0040_3ABC, 1'b0, 2'd3, 3'b111, 3'b111, 0);
        run_case("R3 R12 sup write lat", 32'hFFC0_0FFF, 1'b1, 2'd0, 3'b111, 3'b111, 3);
        run_case("R12 long latency",    32'h1234_5678, 1'b0, 2'd2, 3'b011, 3'b001, 7);
    endtask

    task automatic t_not_present();
        run_case("R4 dir np user",      32'h0080_1000, 1'b0, 2'd3, 3'b110, 3'b111, 1);
        run_case("R4 R9 dir np sup wr", 32'h00C0_2000, 1'b1, 2'd0, 3'b000, 3'b111, 0);
        run_case("R5 R9 tbl np sup wr", 32'h0100_3000, 1'b1, 2'd0, 3'b111, 3'b110, 2);
        run_case("R5 R9 tbl np user",   32'h0140_4000, 1'b0, 2'd3, 3'b111, 3'b000, 0);
    endtask

    task automatic t_user_bit();
        run_case("R6 R9 dir US0 user rd", 32'h0180_5000, 1'b0, 2'd3, 3'b011, 3'b111, 0);
        run_case("R6 dir US0 lvl1 rd",    32'h0180_5000, 1'b0, 2'd1, 3'b011, 3'b111, 0);
        run_case("R6 R9 tbl US0 user wr", 32'h01C0_6000, 1'b1, 2'd3, 3'b111, 3'b011, 1);
        run_case("R6 tbl US0 lvl2 wr",    32'h01C0_6000, 1'b1, 2'd2, 3'b111, 3'b011, 1);
    endtask

    task automatic t_write_bit();
        run_case("R7 tbl RO user wr",  32'h0200_7000, 1'b1, 2'd3, 3'b111, 3'b101, 0);
        run_case("R7 tbl RO user rd",  32'h0200_7000, 1'b0, 2'd3, 3'b111, 3'b101, 0);
        run_case("R7 tbl RO lvl2 wr",  32'h0200_7000, 1'b1, 2'd2, 3'b111, 3'b101, 0);
        run_case("R7 dir RO user wr",  32'h0240_8000, 1'b1, 2'd3, 3'b101, 3'b111, 2);
    endtask

    task automatic t_rw_ignored();
        run_case("R8 US0 RW1 user rd",   32'h0280_9000, 1'b0, 2'd3, 3'b011, 3'b111, 0);
        run_case("R8 US0 RW0 user rd",   32'h0280_9000, 1'b0, 2'd3, 3'b001, 3'b111, 0);
        run_case("R8 no loosen user wr", 32'h02C0_A000, 1'b1, 2'd3, 3'b001, 3'b111, 0);
    endtask

    task automatic t_busy();
        intrude = 1;
        run_case("R11 busy ignored", 32'h0300_B123, 1'b0, 2'd3, 3'b111, 3'b111, 4);
        intrude = 0;
        chk("R11 ready low while busy", {31'd0, saw_ready_busy}, 32'd0);
    endtask

    task automatic t_base();
        load_base(32'h0077_7ABC);
        run_case("R13 new base", 32'h0340_C456, 1'b1, 2'd3, 3'b111, 3'b111, 1);
    endtask

    initial begin
        rst = 1'b1; cfg_base_we = 1'b0; cfg_base_wdata = '0;
        req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_cpl = '0;
        mem_rd_valid = 1'b0; mem_rd_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        load_base(dir_base);
        t_translate();
        t_not_present();
        t_user_bit();
        t_write_bit();
        t_rw_ignored();
        t_busy();
        t_base();
        summary();
        $finish;
    end
endmodule